// File: doc/BRIEF.md
# Three-Wire Serial Register Access Port

This block is the control-port slave of a converter-style device. An external host reaches it over three pins: an active-low select, a serial clock and a single data line that the block either samples or drives. Every access opens with a 16-bit instruction. The instruction carries a direction flag, a two-bit length code and a 13-bit start address. One or more 8-bit data bytes follow, and the register address moves forward by one for each byte. Toward the inside of the device, the block presents a plain parallel register bus: an address, a one-cycle write strobe with data, and a one-cycle read strobe whose data returns in the same cycle.

All three pins pass through a synchronizer into the block's own clock domain, and the edges are detected there. The serial clock must therefore run several times slower than the block clock. The block also keeps a mode flag. Reset leaves the device under pin control. The first falling edge of the select moves it to serial control for good. At that moment the idle levels of the data and clock pins are captured as starting values for the output standard and the data format. Register writes may later replace them.

Top module: `spi3w_regport`

## Requirements
- R1: The instruction is 16 bits, most significant bit first. Bit 15 is the direction (1 = read, 0 = write), bits 14:13 are the length code, and bits 12:0 are the start address.
- R2: Length codes 0, 1 and 2 allow 1, 2 and 3 data bytes. Bytes clocked past that allowance raise no write strobe.
- R3: Length code 3 streams. Every complete byte is transferred until the select goes high.
- R4: The address steps by one per data byte and wraps from 0x1FFF to 0x0000.
- R5: A complete write byte, received MSB first, produces one `reg_we_o` pulse lasting a single cycle. The pulse carries the byte's address and data, and the address output advances in the following cycle.
- R6: A byte cut short by the select going high produces no write strobe.
- R7: When the last clock rise of a byte and the select rise reach the block together, that byte is still written.
- R8: In a read, each byte within the allowance is fetched with a single-cycle `reg_re_o` pulse. It is shifted out MSB first, one bit per falling clock edge, with `sdio_oe_o` high.
- R9: Read bytes past the allowance raise no read strobe. For those bytes `sdio_oe_o` is low and `sdio_o` is 0.
- R10: After reset the block is in pin-control mode (`serial_mode_o` = 0). The driver is off and the starting settings are 0.
- R11: The first select fall after reset sets `serial_mode_o` and pulses `mode_load_o` once. It captures the data pin level into `out_std_o` and the clock pin level into `data_fmt_o` (high gives 01, two's complement; low gives 00, offset binary). Later select falls change none of these.
- R12: `data_fmt_o` never takes the Gray-code value 10 from pin capture.
- R13: Once the select has been high for more than SYNC_STAGES+2 cycles, `sdio_oe_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_ni | input | 1 | Serial select, active low |
| sclk_i | input | 1 | Serial clock |
| sdio_i | input | 1 | Data line, sampled value |
| sdio_o | output | 1 | Data line, driven value |
| sdio_oe_o | output | 1 | Data line driver enable |
| reg_addr_o | output | 13 | Register bus address |
| reg_wdata_o | output | 8 | Register bus write data |
| reg_we_o | output | 1 | Register write strobe |
| reg_re_o | output | 1 | Register read strobe |
| reg_rdata_i | input | 8 | Register read data, valid while the read strobe is high |
| serial_mode_o | output | 1 | 1 once serial control is active |
| out_std_o | output | 1 | Captured starting output standard |
| data_fmt_o | output | 2 | Captured starting data format |
| mode_load_o | output | 1 | One-cycle pulse when the starting settings are captured |

## Verification
A byte completion and an end of access can land in the same block cycle. When that happens, the byte's write strobe and the return to idle must both take effect. The bench provokes this by raising the select at the same instant as the final clock rise, so both synchronizers deliver their edges together. It judges the result by the count and content of the write strobes. The other shared cycle is the first select fall, which both captures the mode and starts a new instruction. That access must decode correctly, and the captured levels are checked before and after a second reset with the pin levels reversed.

// File: rtl/spi3w_pkg.sv
`timescale 1ns/1ps
package spi3w_pkg;
  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_INSTR = 2'd1,
    PH_DATA  = 2'd2
  } phase_e;

  typedef enum logic [1:0] {
    FMT_OFFSET = 2'b00,
    FMT_TWOS   = 2'b01,
    FMT_GRAY   = 2'b10
  } fmt_e;

  localparam logic [1:0] LEN_STREAM = 2'b11;
  localparam int unsigned CTL_W = 3;  // direction + length code
endpackage

// File: rtl/spi3w_sync_edge.sv
`timescale 1ns/1ps
module spi3w_sync_edge #(
  parameter int unsigned   WIDTH   = 3,
  parameter int unsigned   STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o,
  output logic [WIDTH-1:0] prev_o,
  output logic [WIDTH-1:0] rise_o,
  output logic [WIDTH-1:0] fall_o
);
  logic [WIDTH-1:0] chain_q [STAGES];
  logic [WIDTH-1:0] prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < STAGES; s++) chain_q[s] <= RST_VAL;
      prev_q <= RST_VAL;
    end else begin
      chain_q[0] <= d_i;
      for (int s = 1; s < STAGES; s++) chain_q[s] <= chain_q[s-1];
      prev_q <= chain_q[STAGES-1];
    end
  end

  assign q_o    = chain_q[STAGES-1];
  assign prev_o = prev_q;

  for (genvar b = 0; b < WIDTH; b++) begin : g_edge
    assign rise_o[b] =  q_o[b] & ~prev_q[b];
    assign fall_o[b] = ~q_o[b] &  prev_q[b];
  end
endmodule

// File: rtl/spi3w_mode_latch.sv
`timescale 1ns/1ps
module spi3w_mode_latch
  import spi3w_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       cs_fall_i,
  input  logic       sdio_lvl_i,
  input  logic       sclk_lvl_i,
  output logic       serial_mode_o,
  output logic       out_std_o,
  output logic [1:0] data_fmt_o,
  output logic       mode_load_o
);
  logic serial_q, std_q, load_q;
  fmt_e fmt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      serial_q <= 1'b0;
      std_q    <= 1'b0;
      fmt_q    <= FMT_OFFSET;
      load_q   <= 1'b0;
    end else begin
      load_q <= 1'b0;
      if (cs_fall_i && !serial_q) begin
        serial_q <= 1'b1;
        std_q    <= sdio_lvl_i;
        // pin capture reaches only the two binary formats
        fmt_q    <= sclk_lvl_i ? FMT_TWOS : FMT_OFFSET;
        load_q   <= 1'b1;
      end
    end
  end

  assign serial_mode_o = serial_q;
  assign out_std_o     = std_q;
  assign data_fmt_o    = fmt_q;
  assign mode_load_o   = load_q;
endmodule

// File: rtl/spi3w_frame.sv
`timescale 1ns/1ps
module spi3w_frame
  import spi3w_pkg::*;
#(
  parameter int unsigned ADDR_W = 13,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sel_i,
  input  logic              cs_fall_i,
  input  logic              cs_rise_i,
  input  logic              sck_rise_i,
  input  logic              sck_fall_i,
  input  logic              sdi_i,
  output logic [ADDR_W-1:0] reg_addr_o,
  output logic [DATA_W-1:0] reg_wdata_o,
  output logic              reg_we_o,
  output logic              reg_re_o,
  input  logic [DATA_W-1:0] reg_rdata_i,
  output logic              sdo_o,
  output logic              sdo_oe_o
);
  localparam int unsigned INSTR_W = ADDR_W + CTL_W;
  localparam int unsigned ICNT_W  = $clog2(INSTR_W);
  localparam int unsigned BIT_W   = $clog2(DATA_W);
  localparam int unsigned NB_W    = 3;
  localparam logic [ICNT_W-1:0] ICNT_LAST = ICNT_W'(INSTR_W - 1);
  localparam logic [BIT_W-1:0]  BIT_LAST  = BIT_W'(DATA_W - 1);
  localparam logic [NB_W-1:0]   NB_SAT    = NB_W'(4);

  function automatic logic in_range(input logic [1:0] len, input logic [NB_W-1:0] n);
    return (len == LEN_STREAM) || (n <= {1'b0, len});
  endfunction

  phase_e             phase_q;
  logic [ICNT_W-1:0]  icnt_q;
  logic [BIT_W-1:0]   bit_q;
  logic [INSTR_W-1:0] ish_q;
  logic [DATA_W-1:0]  rx_q, tx_q, wdata_q;
  logic [ADDR_W-1:0]  addr_q;
  logic [1:0]         len_q;
  logic [NB_W-1:0]    nb_q;
  logic               rd_q, pf_q, we_q, sdo_q, oe_q;

  logic               take, drop, cur_in, nxt_in;
  logic [INSTR_W-1:0] ish_nxt;
  logic [DATA_W-1:0]  rx_nxt;
  logic [NB_W-1:0]    nb_inc;

  always_comb begin
    take    = sel_i & sck_rise_i;
    drop    = sel_i & sck_fall_i;
    ish_nxt = {ish_q[INSTR_W-2:0], sdi_i};
    rx_nxt  = {rx_q[DATA_W-2:0], sdi_i};
    nb_inc  = (nb_q == NB_SAT) ? nb_q : nb_q + 1'b1;
    cur_in  = in_range(len_q, nb_q);
    nxt_in  = in_range(len_q, nb_inc);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_IDLE;
      icnt_q  <= '0;
      bit_q   <= '0;
      ish_q   <= '0;
      rx_q    <= '0;
      tx_q    <= '0;
      wdata_q <= '0;
      addr_q  <= '0;
      len_q   <= '0;
      nb_q    <= '0;
      rd_q    <= 1'b0;
      pf_q    <= 1'b0;
      we_q    <= 1'b0;
      sdo_q   <= 1'b0;
      oe_q    <= 1'b0;
    end else begin
      we_q <= 1'b0;
      if (we_q) addr_q <= addr_q + 1'b1;
      if (pf_q) begin
        pf_q <= 1'b0;
        tx_q <= reg_rdata_i;
      end
      if (cs_fall_i) begin
        phase_q <= PH_INSTR;
        icnt_q  <= '0;
        bit_q   <= '0;
        nb_q    <= '0;
        oe_q    <= 1'b0;
        sdo_q   <= 1'b0;
      end else begin
        if (take && phase_q == PH_INSTR) begin
          ish_q  <= ish_nxt;
          icnt_q <= icnt_q + 1'b1;
          if (icnt_q == ICNT_LAST) begin
            phase_q <= PH_DATA;
            rd_q    <= ish_nxt[INSTR_W-1];
            len_q   <= ish_nxt[INSTR_W-2 -: 2];
            addr_q  <= ish_nxt[ADDR_W-1:0];
            pf_q    <= ish_nxt[INSTR_W-1];
            bit_q   <= '0;
            nb_q    <= '0;
            tx_q    <= '0;
          end
        end
        if (take && phase_q == PH_DATA) begin
          rx_q  <= rx_nxt;
          bit_q <= (bit_q == BIT_LAST) ? '0 : bit_q + 1'b1;
          if (bit_q == BIT_LAST) begin
            nb_q <= nb_inc;
            if (rd_q) begin
              addr_q <= addr_q + 1'b1;
              pf_q   <= nxt_in;
              tx_q   <= '0;
            end else if (cur_in) begin
              we_q    <= 1'b1;
              wdata_q <= rx_nxt;
            end
          end
        end
        if (drop && phase_q == PH_DATA && rd_q) begin
          if (cur_in) begin
            sdo_q <= tx_q[DATA_W-1];
            tx_q  <= {tx_q[DATA_W-2:0], 1'b0};
            oe_q  <= 1'b1;
          end else begin
            sdo_q <= 1'b0;
            oe_q  <= 1'b0;
          end
        end
        // deselect closes the frame; a byte completed in this cycle keeps its strobe
        if (cs_rise_i) begin
          phase_q <= PH_IDLE;
          pf_q    <= 1'b0;
          oe_q    <= 1'b0;
          sdo_q   <= 1'b0;
        end
      end
    end
  end

  assign reg_addr_o  = addr_q;
  assign reg_wdata_o = wdata_q;
  assign reg_we_o    = we_q;
  assign reg_re_o    = pf_q;
  assign sdo_o       = sdo_q;
  assign sdo_oe_o    = oe_q;
endmodule

// File: rtl/spi3w_regport.sv
`timescale 1ns/1ps
module spi3w_regport
  import spi3w_pkg::*;
#(
  parameter int unsigned ADDR_W      = 13,
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_ni,
  input  logic              sclk_i,
  input  logic              sdio_i,
  output logic              sdio_o,
  output logic              sdio_oe_o,
  output logic [ADDR_W-1:0] reg_addr_o,
  output logic [DATA_W-1:0] reg_wdata_o,
  output logic              reg_we_o,
  output logic              reg_re_o,
  input  logic [DATA_W-1:0] reg_rdata_i,
  output logic              serial_mode_o,
  output logic              out_std_o,
  output logic [1:0]        data_fmt_o,
  output logic              mode_load_o
);
  localparam int unsigned N_LINES = 3;
  localparam int unsigned L_CS    = 0;
  localparam int unsigned L_SCK   = 1;
  localparam int unsigned L_SDI   = 2;
  localparam logic [N_LINES-1:0] LINE_RST = N_LINES'(1) << L_CS;

  logic [N_LINES-1:0] raw, lvl, prev, rise, fall;
  logic               unused_edges;

  assign raw = {sdio_i, sclk_i, cs_ni};

  spi3w_sync_edge #(
    .WIDTH  (N_LINES),
    .STAGES (SYNC_STAGES),
    .RST_VAL(LINE_RST)
  ) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (raw),
    .q_o   (lvl),
    .prev_o(prev),
    .rise_o(rise),
    .fall_o(fall)
  );

  assign unused_edges = ^{rise[L_SDI], fall[L_SDI], prev[L_SDI], prev[L_SCK], lvl[L_CS]};

  spi3w_mode_latch u_mode (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .cs_fall_i    (fall[L_CS]),
    .sdio_lvl_i   (lvl[L_SDI]),
    .sclk_lvl_i   (lvl[L_SCK]),
    .serial_mode_o(serial_mode_o),
    .out_std_o    (out_std_o),
    .data_fmt_o   (data_fmt_o),
    .mode_load_o  (mode_load_o)
  );

  spi3w_frame #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
  ) u_frame (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sel_i      (~prev[L_CS]),
    .cs_fall_i  (fall[L_CS]),
    .cs_rise_i  (rise[L_CS]),
    .sck_rise_i (rise[L_SCK]),
    .sck_fall_i (fall[L_SCK]),
    .sdi_i      (lvl[L_SDI]),
    .reg_addr_o (reg_addr_o),
    .reg_wdata_o(reg_wdata_o),
    .reg_we_o   (reg_we_o),
    .reg_re_o   (reg_re_o),
    .reg_rdata_i(reg_rdata_i),
    .sdo_o      (sdio_o),
    .sdo_oe_o   (sdio_oe_o)
  );
endmodule

// File: rtl/spi3w_regport_chk.sv
`timescale 1ns/1ps
module spi3w_regport_chk #(
  parameter int unsigned ADDR_W      = 13,
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cs_ni,
  input logic              sdio_o,
  input logic              sdio_oe_o,
  input logic [ADDR_W-1:0] reg_addr_o,
  input logic              reg_we_o,
  input logic              reg_re_o,
  input logic              serial_mode_o,
  input logic [1:0]        data_fmt_o,
  input logic              mode_load_o
);
  localparam int unsigned HOLD = SYNC_STAGES + 3;
  logic [7:0] hi_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               hi_q <= '0;
    else if (!cs_ni)           hi_q <= '0;
    else if (hi_q != 8'(HOLD)) hi_q <= hi_q + 1'b1;
  end

  AST_WE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_we_o |=> !reg_we_o); // R5
  AST_ADDR_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_we_o |=> reg_addr_o == $past(reg_addr_o) + 1'b1); // R4
  AST_RE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_re_o |=> !reg_re_o); // R8
  AST_STROBE_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(reg_we_o && reg_re_o)); // R8
  AST_IDLE_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sdio_oe_o |-> !sdio_o); // R9
  AST_MODE_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    serial_mode_o |=> serial_mode_o && !mode_load_o); // R11
  AST_MODE_ENTRY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(serial_mode_o) |-> mode_load_o); // R11
  AST_NO_PIN_GRAY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_load_o |-> data_fmt_o != 2'b10); // R12
  AST_OE_DESEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hi_q == 8'(HOLD)) |-> !sdio_oe_o); // R13
endmodule

bind spi3w_regport spi3w_regport_chk #(
  .ADDR_W(ADDR_W),
  .DATA_W(DATA_W),
  .SYNC_STAGES(SYNC_STAGES)
) u_chk (.*);

// File: tb/spi3w_regport_bench.sv
`timescale 1ns/1ps
module spi3w_regport_bench;
  localparam int HALF = 8;
  localparam int NV   = 11;
  // {rw, len[1:0], addr[12:0], nbytes[2:0], seed[7:0]}
  localparam logic [26:0] VEC [NV] = '{
    {1'b0, 2'b00, 13'h0010, 3'd1, 8'hA1},
    {1'b0, 2'b01, 13'h0020, 3'd2, 8'hB2},
    {1'b0, 2'b10, 13'h0123, 3'd3, 8'hC3},
    {1'b0, 2'b00, 13'h0040, 3'd3, 8'hD4},
    {1'b0, 2'b11, 13'h0050, 3'd5, 8'hE5},
    {1'b0, 2'b01, 13'h1FFF, 3'd2, 8'hF6},
    {1'b1, 2'b00, 13'h0100, 3'd2, 8'h00},
    {1'b1, 2'b01, 13'h0A5C, 3'd2, 8'h00},
    {1'b1, 2'b11, 13'h1FFE, 3'd3, 8'h00},
    {1'b1, 2'b10, 13'h0007, 3'd4, 8'h00},
    {1'b0, 2'b11, 13'h0000, 3'd1, 8'h17}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1, sclk = 1'b0, sdio = 1'b0;
  logic sdo, oe, we, re, smode, ostd, mload;
  logic [12:0] raddr;
  logic [7:0]  wdata, rdata;
  logic [1:0]  dfmt;

  int checks = 0, fails = 0;
  int wcnt = 0, rcnt = 0, lcnt = 0;
  logic [12:0] wlog_a [64];
  logic [7:0]  wlog_d [64];
  logic [7:0]  rd_b [8];
  logic        rd_all [8];
  logic        rd_any [8];

  always #2.5 clk = ~clk;

  function automatic logic [7:0] model(input logic [12:0] a);
    return a[7:0] ^ {a[12:8], 3'b101};
  endfunction

  function automatic logic [7:0] wdat(input logic [7:0] seed, input int k);
    return seed + 8'(k * 37);
  endfunction

  assign rdata = model(raddr);

  spi3w_regport u_spi3w_regport (
    .clk_i(clk), .rst_ni(rst_n), .cs_ni(cs_n), .sclk_i(sclk), .sdio_i(sdio),
    .sdio_o(sdo), .sdio_oe_o(oe), .reg_addr_o(raddr), .reg_wdata_o(wdata),
    .reg_we_o(we), .reg_re_o(re), .reg_rdata_i(rdata),
    .serial_mode_o(smode), .out_std_o(ostd), .data_fmt_o(dfmt), .mode_load_o(mload)
  );

  always @(negedge clk) begin
    if (we) begin
      if (wcnt < 64) begin
        wlog_a[wcnt] = raddr;
        wlog_d[wcnt] = wdata;
      end
      wcnt++;
    end
    if (re) rcnt++;
    if (mload) lcnt++;
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic half();
    repeat (HALF) @(negedge clk);
  endtask

  task automatic run_txn(input logic rw, input logic [1:0] len, input logic [12:0] addr,
                         input int nbytes, input int extra_bits, input logic [7:0] seed,
                         input bit cs_last);
    logic [15:0] ins;
    ins = {rw, len, addr};
    cs_n = 1'b0;
    half();
    for (int i = 15; i >= 0; i--) begin
      sclk = 1'b0; sdio = ins[i]; half();
      sclk = 1'b1; half();
    end
    for (int k = 0; k < nbytes; k++) begin
      logic [7:0] wb;
      wb = wdat(seed, k);
      rd_b[k] = '0; rd_all[k] = 1'b1; rd_any[k] = 1'b0;
      for (int j = 7; j >= 0; j--) begin
        sclk = 1'b0; sdio = rw ? 1'b0 : wb[j]; half();
        rd_b[k][j] = sdo;
        rd_all[k] = rd_all[k] & oe;
        rd_any[k] = rd_any[k] | oe;
        sclk = 1'b1;
        if (cs_last && k == nbytes - 1 && j == 0 && extra_bits == 0) cs_n = 1'b1;
        half();
      end
    end
    for (int j = 0; j < extra_bits; j++) begin
      sclk = 1'b0; sdio = 1'b1; half();
      sclk = 1'b1; half();
    end
    cs_n = 1'b1;
    half(); half();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    // R10 reset state
    chk("R10 serial_mode after reset", smode, 0);
    chk("R10 oe after reset", oe, 0);
    chk("R10 fmt after reset", dfmt, 0);
    chk("R10 no strobes", wcnt + rcnt + lcnt, 0);

    sdio = 1'b1; sclk = 1'b1;
    half();
    for (int v = 0; v < NV; v++) begin
      logic        rw;
      logic [1:0]  len;
      logic [12:0] addr;
      int          nb, lim, nexp, w0, r0;
      logic [7:0]  seed;
      rw = VEC[v][26]; len = VEC[v][25:24]; addr = VEC[v][23:11];
      nb = int'(VEC[v][10:8]); seed = VEC[v][7:0];
      lim = (len == 2'b11) ? 99 : int'(len) + 1;
      w0 = wcnt; r0 = rcnt;
      run_txn(rw, len, addr, nb, 0, seed, 1'b0);
      if (!rw) begin
        nexp = (nb < lim) ? nb : lim;
        chk(len == 2'b11 ? "R3 stream write count" : "R2 write count", wcnt - w0, nexp);
        for (int i = 0; i < nexp; i++) begin
          chk(i == 0 ? "R1 start addr" : "R4 addr step", wlog_a[w0 + i], int'(13'(addr + 13'(i))));
          chk("R5 write data", wlog_d[w0 + i], wdat(seed, i));
        end
      end else begin
        nexp = 1 + ((nb < lim - 1) ? nb : lim - 1);
        chk("R8 read strobe count", rcnt - r0, nexp);
        for (int k = 0; k < nb; k++) begin
          if (k < lim) begin
            chk("R8 read data", rd_b[k], model(13'(addr + 13'(k))));
            chk("R8 oe during read", rd_all[k], 1);
          end else begin
            chk("R9 read beyond data", rd_b[k], 0);
            chk("R9 oe beyond count", rd_any[k], 0);
          end
        end
      end
      chk("R13 oe after deselect", oe, 0);
      if (v == 0) begin
        chk("R11 serial mode set", smode, 1);
        chk("R11 std captured", ostd, 1);
        chk("R11 fmt captured", dfmt, 2'b01);
        chk("R11 one load", lcnt, 1);
        sdio = 1'b0; sclk = 1'b0;
      end
    end
    chk("R11 std kept", ostd, 1);
    chk("R12 fmt kept", dfmt, 2'b01);
    chk("R11 load count", lcnt, 1);

    // R6 partial byte dropped
    begin
      int w0;
      w0 = wcnt;
      run_txn(1'b0, 2'b11, 13'h0300, 1, 4, 8'h3C, 1'b0);
      chk("R6 partial byte", wcnt - w0, 1);
      chk("R6 kept byte addr", wlog_a[w0], 13'h0300);
      // R7 last rise together with deselect
      w0 = wcnt;
      run_txn(1'b0, 2'b00, 13'h0310, 1, 0, 8'h5A, 1'b1);
      chk("R7 write on deselect edge", wcnt - w0, 1);
      chk("R7 data", wlog_d[w0], 8'h5A);
      w0 = wcnt;
      run_txn(1'b0, 2'b01, 13'h0400, 2, 0, 8'h11, 1'b0);
      chk("R1 fresh frame count", wcnt - w0, 2);
      chk("R1 fresh frame addr", wlog_a[w0], 13'h0400);
    end

    // second reset, opposite pin levels
    begin
      int l0;
      rst_n = 1'b0;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      repeat (4) @(negedge clk);
      chk("R10 pin mode after reset", smode, 0);
      chk("R10 std after reset", ostd, 0);
      sdio = 1'b0; sclk = 1'b0;
      half();
      l0 = lcnt;
      run_txn(1'b1, 2'b00, 13'h0005, 1, 0, 8'h00, 1'b0);
      chk("R11 serial again", smode, 1);
      chk("R11 std low captured", ostd, 0);
      chk("R12 fmt low captured", dfmt, 2'b00);
      chk("R11 load after reset", lcnt - l0, 1);
      chk("R8 read after reset", rd_b[0], model(13'h0005));
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule